// File: doc/BRIEF.md
# Variable-Length Bit Packer with Flush

This block gathers bit fields of varying length, from zero up to a full word, and concatenates them most significant bit first into 32-bit words. Whenever the concatenation reaches a whole word, that word is presented on the word output with a one-cycle valid strobe. Any leftover bits of the field that crossed the boundary begin the next word in the same cycle. It is meant to sit after a code-generation stage in an entropy coder, where every symbol yields a codeword of its own length.

A field may carry a flush flag. The field is packed first. Any bits still waiting in the partial word are then sent on a separate flush output. The unused low positions of that word are filled with ones, and an index gives the last byte that holds real data. The bit pointer then returns to zero, so the next field starts a fresh word. A stall input freezes the whole block, including both outputs.

Top module: `vlc_bit_packer`

## Requirements
- R1: A field is given as `inLen` (0 to 32) and the low `inLen` bits of `inBits`. Bits of `inBits` above `inLen` are ignored. Fields are packed most significant bit first, and the first field after reset lands at bit 31 of the word.
- R2: When the packed bits reach 32, `wordOut` shows the word and `wordValid` is high on the first clock edge after the edge that accepted the completing field.
- R3: Bits of a field that cross a word boundary become the leading bits of the next word, with no lost cycle and no gap.
- R4: A field with `inFlush` set is packed first. If bits then remain in the partial word, `flushOut` shows them on the next edge, with all unused lower positions set to one, and `flushValid` is high.
- R5: `flushLastByte` equals (n-1)/8, where n is the number of data bits in the flushed word. Byte 0 is bits 31:24 and byte 3 is bits 7:0.
- R6: After a flush, the next field starts at bit 31 of a new word.
- R7: A flush with no bits remaining asserts no `flushValid`. This covers a zero-length field on an empty word, and a field that completes a word exactly, which goes out on `wordOut` only.
- R8: While `stall` is high, input is ignored and all state and every output hold their values.
- R9: `wordValid` and `flushValid` are one-cycle strobes. After any unstalled cycle that produces no word or no flush, the matching strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Field present this cycle |
| inBits | input | 32 | Field bits, right-aligned |
| inLen | input | 6 | Field length, 0 to 32 |
| inFlush | input | 1 | Flush after this field |
| stall | input | 1 | Freeze the block |
| wordOut | output | 32 | Completed word |
| wordValid | output | 1 | Strobe for `wordOut` |
| flushOut | output | 32 | Flushed partial word, padded with ones |
| flushValid | output | 1 | Strobe for `flushOut` |
| flushLastByte | output | 2 | Index of the last byte with data |

## Verification
Each output of this block is registered once, so the word, the flush word, their strobes and the byte index all follow one clock edge after the edge that accepts the field. A stall holds them at that point for as long as it lasts. The bench drives inputs on the falling edge. At the next falling edge it compares every output against a bit-queue model that was advanced when those inputs were applied. It skips the model step in stalled cycles, so the expected values stay frozen exactly as the hardware should. Directed cases cover exact fills, boundary crossings, flushes at each byte index, empty flushes and stalls. A long random stream follows.

// File: rtl/vlc_pack_pkg.sv
package vlc_pack_pkg;
  typedef struct packed {
    logic advance;   // field accepted this cycle
    logic wrap;      // a whole word completes
    logic flushNow;  // partial word leaves on flush port
    logic clear;     // pointer returns to word start
  } pack_ctl_t;
endpackage

// File: rtl/vlc_pack_ctrl.sv
module vlc_pack_ctrl
  import vlc_pack_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int LEN_W  = $clog2(WORD_W) + 1,
  localparam int BYTE_W = $clog2(WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [LEN_W-1:0]  inLen,
  input  logic              inFlush,
  input  logic              stall,
  output logic [LEN_W-1:0]  fill,
  output logic [LEN_W-1:0]  rem,
  output pack_ctl_t         ctl,
  output logic              wordValid,
  output logic              flushValid,
  output logic [BYTE_W-1:0] flushLastByte
);
  logic [LEN_W:0]   total;
  logic [LEN_W:0]   remWide;
  logic [LEN_W-1:0] remMinus1;
  logic             wrap;
  logic             fire;

  always_comb begin
    fire      = inValid && !stall;
    total     = {1'b0, fill} + {1'b0, inLen};
    wrap      = total >= (LEN_W + 1)'(WORD_W);
    remWide   = wrap ? total - (LEN_W + 1)'(WORD_W) : total;
    rem       = remWide[LEN_W-1:0];
    remMinus1 = rem - 1'b1;
    ctl.advance  = fire;
    ctl.wrap     = fire && wrap;
    ctl.flushNow = fire && inFlush && (rem != '0);
    ctl.clear    = fire && inFlush;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fill          <= '0;
      wordValid     <= 1'b0;
      flushValid    <= 1'b0;
      flushLastByte <= '0;
    end else if (!stall) begin
      wordValid  <= ctl.wrap;
      flushValid <= ctl.flushNow;
      if (ctl.flushNow) flushLastByte <= remMinus1[3 +: BYTE_W];
      if (ctl.advance)  fill <= ctl.clear ? '0 : rem;
    end
  end
endmodule

// File: rtl/vlc_pack_data.sv
module vlc_pack_data
  import vlc_pack_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int LEN_W = $clog2(WORD_W) + 1,
  localparam int DW    = 2 * WORD_W,
  localparam int SH_W  = $clog2(DW) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  logic [WORD_W-1:0] inBits,
  input  logic [LEN_W-1:0]  inLen,
  input  logic [LEN_W-1:0]  fill,
  input  logic [LEN_W-1:0]  rem,
  input  pack_ctl_t         ctl,
  output logic [WORD_W-1:0] wordOut,
  output logic [WORD_W-1:0] flushOut
);
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] fieldMask;
  logic [DW-1:0]     fieldWide;
  logic [SH_W-1:0]   shamt;
  logic [DW-1:0]     joined;
  logic [WORD_W-1:0] nextAcc;
  logic [WORD_W-1:0] padMask;

  always_comb begin
    fieldMask = (inLen >= LEN_W'(WORD_W)) ? {WORD_W{1'b1}}
                                          : ~({WORD_W{1'b1}} << inLen);
    fieldWide = {{WORD_W{1'b0}}, inBits & fieldMask};
    shamt     = SH_W'(DW) - SH_W'(fill) - SH_W'(inLen);
    joined    = {acc, {WORD_W{1'b0}}} | (fieldWide << shamt);
    nextAcc   = ctl.wrap ? joined[WORD_W-1:0] : joined[DW-1:WORD_W];
    padMask   = {WORD_W{1'b1}} >> rem;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      wordOut  <= '0;
      flushOut <= '0;
    end else if (!stall) begin
      if (ctl.wrap)     wordOut  <= joined[DW-1:WORD_W];
      if (ctl.flushNow) flushOut <= nextAcc | padMask;
      if (ctl.advance)  acc      <= ctl.clear ? '0 : nextAcc;
    end
  end
endmodule

// File: rtl/vlc_bit_packer.sv
module vlc_bit_packer
  import vlc_pack_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int LEN_W  = $clog2(WORD_W) + 1,
  localparam int BYTE_W = $clog2(WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inBits,
  input  logic [LEN_W-1:0]  inLen,
  input  logic              inFlush,
  input  logic              stall,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid,
  output logic [WORD_W-1:0] flushOut,
  output logic              flushValid,
  output logic [BYTE_W-1:0] flushLastByte
);
  pack_ctl_t        ctl;
  logic [LEN_W-1:0] fill;
  logic [LEN_W-1:0] rem;

  vlc_pack_ctrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLen(inLen),
    .inFlush(inFlush), .stall(stall), .fill(fill), .rem(rem), .ctl(ctl),
    .wordValid(wordValid), .flushValid(flushValid),
    .flushLastByte(flushLastByte)
  );

  vlc_pack_data #(.WORD_W(WORD_W)) data_i (
    .clk(clk), .rstN(rstN), .stall(stall), .inBits(inBits), .inLen(inLen),
    .fill(fill), .rem(rem), .ctl(ctl), .wordOut(wordOut), .flushOut(flushOut)
  );
endmodule

// File: rtl/vlc_bit_packer_chk.sv
module vlc_bit_packer_chk #(
  parameter int WORD_W = 32,
  localparam int LEN_W  = $clog2(WORD_W) + 1,
  localparam int BYTE_W = $clog2(WORD_W / 8)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [WORD_W-1:0] inBits,
  input logic [LEN_W-1:0]  inLen,
  input logic              inFlush,
  input logic              stall,
  input logic [WORD_W-1:0] wordOut,
  input logic              wordValid,
  input logic [WORD_W-1:0] flushOut,
  input logic              flushValid,
  input logic [BYTE_W-1:0] flushLastByte
);
  logic [WORD_W-1:0] tailMask;
  always_comb tailMask = {WORD_W{1'b1}} >> (8 * (32'(flushLastByte) + 1));

  a_r1_len_range: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> (inLen <= LEN_W'(WORD_W)));

  a_r4_pad_ones: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> ((flushOut & tailMask) == tailMask));

  a_r8_stall_freeze: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(wordOut) && $stable(wordValid) && $stable(flushOut)
               && $stable(flushValid) && $stable(flushLastByte)));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !inValid) |=> (!wordValid && !flushValid));

  a_r7_flush_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !(inValid && inFlush)) |=> !flushValid);
endmodule

bind vlc_bit_packer vlc_bit_packer_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inBits(inBits), .inLen(inLen),
  .inFlush(inFlush), .stall(stall), .wordOut(wordOut), .wordValid(wordValid),
  .flushOut(flushOut), .flushValid(flushValid), .flushLastByte(flushLastByte)
);

// File: tb/vlc_bit_packer_tb_top.sv
module vlc_bit_packer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inBits = '0;
  logic [5:0]  inLen = '0;
  logic        inFlush = 1'b0;
  logic        stall = 1'b0;
  logic [31:0] wordOut;
  logic        wordValid;
  logic [31:0] flushOut;
  logic        flushValid;
  logic [1:0]  flushLastByte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  bit          q[$];
  logic [31:0] expWord = '0;
  logic        expWV = 1'b0;
  logic [31:0] expFlush = '0;
  logic        expFV = 1'b0;
  logic [1:0]  expLB = '0;
  string       curTag = "R1";

  always #10 clk = ~clk;

  vlc_bit_packer dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBits(inBits), .inLen(inLen),
    .inFlush(inFlush), .stall(stall), .wordOut(wordOut), .wordValid(wordValid),
    .flushOut(flushOut), .flushValid(flushValid), .flushLastByte(flushLastByte)
  );

  task automatic check(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act %h exp %h", curTag, what, act, exp);
    end
  endtask

  task automatic compare();
    check(wordValid === expWV, "R2 R9 wordValid", 32'(wordValid), 32'(expWV));
    check(wordOut === expWord, "R1 R3 wordOut", wordOut, expWord);
    check(flushValid === expFV, "R4 R7 flushValid", 32'(flushValid), 32'(expFV));
    check(flushOut === expFlush, "R4 R6 flushOut", flushOut, expFlush);
    check(flushLastByte === expLB, "R5 flushLastByte", 32'(flushLastByte), 32'(expLB));
  endtask

  task automatic modelStep();
    if (stall) return;
    expWV = 1'b0;
    expFV = 1'b0;
    if (!inValid) return;
    for (int i = int'(inLen) - 1; i >= 0; i--) q.push_back(inBits[i]);
    if (q.size() >= 32) begin
      for (int i = 31; i >= 0; i--) expWord[i] = q.pop_front();
      expWV = 1'b1;
    end
    if (inFlush && q.size() > 0) begin
      int n = q.size();
      expFlush = '1;
      for (int i = 0; i < n; i++) expFlush[31 - i] = q.pop_front();
      expLB = 2'((n - 1) / 8);
      expFV = 1'b1;
    end
    if (inFlush) q.delete();
  endtask

  task automatic drive(input string tag, input bit v, input logic [31:0] b,
                       input int len, input bit fl, input bit st);
    @(negedge clk);
    compare();
    curTag  = tag;
    inValid = v;
    inBits  = b;
    inLen   = 6'(len);
    inFlush = fl;
    stall   = st;
    modelStep();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curTag = "reset";
    // reset state compared on the first drive call
    // R1: four bytes fill one word exactly; upper junk bits ignored
    drive("R1", 1, 32'hFFFF_FF12, 8, 0, 0);
    drive("R1", 1, 32'h0000_0034, 8, 0, 0);
    drive("R1", 1, 32'hABCD_0056, 8, 0, 0);
    drive("R2", 1, 32'h0000_0078, 8, 0, 0);
    drive("R9", 0, 32'h0, 0, 0, 0);
    // R3: fields crossing a word boundary
    drive("R3", 1, 32'h000F_ACE1, 20, 0, 0);
    drive("R3", 1, 32'h0001_2345, 20, 0, 0);
    drive("R3", 1, 32'h0000_0ABC, 24, 0, 0);
    drive("R3", 1, 32'hDEAD_BEEF, 32, 0, 0);
    // R4 R5 R6: flush at each byte index (pending bits now 0)
    drive("R5", 1, 32'h1, 1, 1, 0);
    drive("R6", 1, 32'h1FF, 9, 1, 0);
    drive("R5", 1, 32'h0012_3456, 23, 1, 0);
    drive("R5", 1, 32'h7FFF_FFFF, 31, 1, 0);
    // R7: empty flush and exact-fill flush
    drive("R7", 1, 32'hFFFF_FFFF, 0, 1, 0);
    drive("R7", 1, 32'hCAFE_F00D, 32, 1, 0);
    drive("R7", 1, 32'h00AB, 16, 0, 0);
    drive("R7", 1, 32'h1234, 16, 1, 0);
    // R4: overflow plus remainder flushed in the same cycle
    drive("R4", 1, 32'h3_FFFF, 18, 0, 0);
    drive("R4", 1, 32'h5_5555, 20, 1, 0);
    // R8: stall holds everything and ignores input
    drive("R8", 1, 32'hFF, 28, 0, 0);
    drive("R8", 1, 32'hF, 4, 0, 0);
    drive("R8", 1, 32'hFFFF_FFFF, 32, 1, 1);
    drive("R8", 1, 32'h0, 32, 1, 1);
    drive("R8", 1, 32'h5, 3, 1, 0);
    drive("R9", 0, 32'h0, 0, 0, 0);
    // random stream
    for (int k = 0; k < 4000; k++) begin
      drive("R2", ($urandom % 4) != 0, $urandom, int'($urandom % 33),
            ($urandom % 16) == 0, ($urandom % 5) == 0);
    end
    drive("R9", 0, 32'h0, 0, 0, 0);
    drive("R9", 0, 32'h0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule